// File: doc/BRIEF.md
# Serial Register Write Port with Pointer Auto-Increment

This block is the write-only serial control slave of a configuration block. A host drives an active-low select, a bit clock and a data line. The port samples these three pins in the system clock domain and finds the rising edges of the bit clock. It then decodes a frame with three parts, sent most significant bit first:
- a header byte: a 7-bit device address followed by a direction bit;
- a pointer byte;
- any number of data bytes.

Each accepted data byte goes to an internal register bank over a valid/ready write channel. The bank accepts one write per cycle. A serial byte takes many system clocks to arrive, so the channel never needs to hold back the serial side, and a byte is never lost to back-pressure. The bank's contents are presented on a flat output vector.

The port also latches a mode flag the first time it sees the select pin fall after reset. This flag tells the surrounding logic to use the serial protocol instead of the two-wire protocol. A select pin that is tied low from power-up never raises the flag. A separate request input restores every register to its computed default value.

Top module: `spi_regwrite_port`

## Requirements
- R1: After reset the mode flag is 0 and register i holds its default value, DFLT_SEED XOR i.
- R2: The mode flag rises on the first high-to-low transition of `spi_cs_n` after reset, stays 1 until the next reset, and stays 0 if `spi_cs_n` is low from reset onward and has not yet risen and fallen.
- R3: Serial bits are taken MSB first on rising edges of `spi_sclk`, and only while `spi_cs_n` is low. Clock edges while the select is high have no effect.
- R4: A frame whose first seven bits differ from DEV_ADDR (default 7'b0010000) writes no register.
- R5: A frame whose eighth bit (direction) is 1 writes no register.
- R6: In the pointer byte, bits 6:0 are the register address and bit 7 is the increment flag. Each following data byte is written to the register the pointer selects.
- R7: With the increment flag at 0, every data byte in the frame goes to the same register, so the last byte wins.
- R8: With the increment flag at 1, the pointer advances by one after each data byte and wraps from 127 to 0.
- R9: A data byte addressed at or above NUM_REGS is dropped and leaves every register unchanged.
- R10: Raising `spi_cs_n` in the middle of a byte discards the partial byte, and the next frame starts again at its header.
- R11: While `defaults_req` is high, all registers return to their defaults. The request takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low serial select, also the mode-detect pin |
| spi_sclk | input | 1 | Serial bit clock, sampled on its rising edge |
| spi_sdi | input | 1 | Serial data in |
| defaults_req | input | 1 | Request to restore all registers to their defaults |
| spi_mode | output | 1 | Latched serial-mode flag |
| reg_image | output | NUM_REGS*8 | Register bank contents, register i in bits 8i+7:8i |

## Verification
The header is swept over all 128 device addresses with both direction values. This separates the single accepting code from every near miss, including one-bit differences in the address and the read direction.

Single-byte writes sweep every pointer value in the bank and a few above it. This tells correct address decoding apart from aliasing. Bursts from every start address, with the increment flag at 0 and at 1, tell the fixed pointer apart from the stepping pointer. A start at 127 exposes the pointer wrap.

Frames cut short mid-byte, bit clocks sent while the select is high, and a select held low from reset test the framing and the mode latch.

// File: rtl/spi_rw_pkg.sv
package spi_rw_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 7;

  typedef enum logic [1:0] {
    FR_HEAD = 2'd0,
    FR_PTR  = 2'd1,
    FR_DATA = 2'd2,
    FR_SKIP = 2'd3
  } frame_st_e;

  function automatic logic [BYTE_W-1:0] reg_default(input logic [BYTE_W-1:0] seed, input int idx);
    return seed ^ BYTE_W'(idx);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sclk_pin,
  input  logic sdi_pin,
  output logic cs_high,
  output logic sclk_rise,
  output logic sdi_bit,
  output logic mode_latched
);
  logic [STAGES-1:0] cs_sr, sclk_sr, sdi_sr;
  logic cs_prev, sclk_prev;

  // Select chain resets low so a pin tied low never looks like a falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr     <= '0;
      sclk_sr   <= '0;
      sdi_sr    <= '0;
      cs_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      cs_sr     <= {cs_sr[STAGES-2:0], cs_n_pin};
      sclk_sr   <= {sclk_sr[STAGES-2:0], sclk_pin};
      sdi_sr    <= {sdi_sr[STAGES-2:0], sdi_pin};
      cs_prev   <= cs_sr[STAGES-1];
      sclk_prev <= sclk_sr[STAGES-1];
    end
  end

  logic cs_fall;
  assign cs_fall   = cs_prev & ~cs_sr[STAGES-1];
  assign cs_high   = cs_sr[STAGES-1];
  assign sclk_rise = ~sclk_prev & sclk_sr[STAGES-1];
  assign sdi_bit   = sdi_sr[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_latched <= 1'b0;
    else if (cs_fall) mode_latched <= 1'b1;
  end

  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_latched |=> mode_latched);
  // R2
  mode_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_latched) |-> $past(cs_prev) && !$past(cs_sr[STAGES-1]));
endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
  import spi_rw_pkg::*;
#(
  parameter logic [PTR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cs_high,
  input  logic              sclk_rise,
  input  logic              sdi_bit,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  frame_st_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  sh_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               inc_q;

  logic               bit_en, byte_done;
  logic [BYTE_W-1:0]  sh_next;

  assign bit_en    = enable & ~cs_high & sclk_rise;
  assign sh_next   = {sh_q[BYTE_W-2:0], sdi_bit};
  assign byte_done = bit_en && (cnt_q == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_HEAD;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      inc_q <= 1'b0;
    end else if (cs_high) begin
      st_q  <= FR_HEAD;
      cnt_q <= '0;
    end else if (bit_en) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= sh_next;
      if (byte_done) begin
        unique case (st_q)
          FR_HEAD: st_q <= (sh_next[BYTE_W-1:1] == DEV_ADDR && !sh_next[0]) ? FR_PTR : FR_SKIP;
          FR_PTR: begin
            ptr_q <= sh_next[PTR_W-1:0];
            inc_q <= sh_next[BYTE_W-1];
            st_q  <= FR_DATA;
          end
          FR_DATA: if (inc_q) ptr_q <= ptr_q + 1'b1;
          FR_SKIP: st_q <= FR_SKIP;
        endcase
      end
    end
  end

  // Write channel: valid is held until the bank takes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (byte_done && st_q == FR_DATA && !cs_high) begin
      wr_valid <= 1'b1;
      wr_addr  <= ptr_q;
      wr_data  <= sh_next;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R4 R5
  write_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> st_q == FR_DATA);
  // R10
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> cnt_q == '0 && st_q == FR_HEAD);
  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st_q == FR_DATA && inc_q) |=> ptr_q == $past(ptr_q) + 1'b1);
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st_q == FR_DATA && !inc_q) |=> $stable(ptr_q));
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_rw_pkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter logic [BYTE_W-1:0] DFLT_SEED = 8'hA0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       defaults_req,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [PTR_W-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] reg_image
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  assign wr_ready = 1'b1;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_valid && wr_ready && (int'(wr_addr) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            regs_q[i] <= reg_default(DFLT_SEED, i);
      else if (defaults_req) regs_q[i] <= reg_default(DFLT_SEED, i);
      else if (hit)          regs_q[i] <= wr_data;
    end
    assign reg_image[i*BYTE_W +: BYTE_W] = regs_q[i];

    // R11
    dflt_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      defaults_req |=> regs_q[i] == reg_default(DFLT_SEED, i));
  end

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && int'(wr_addr) >= NUM_REGS && !defaults_req) |=> $stable(reg_image));
endmodule

// File: rtl/spi_regwrite_port.sv
module spi_regwrite_port
  import spi_rw_pkg::*;
#(
  parameter int                NUM_REGS    = 8,
  parameter logic [PTR_W-1:0]  DEV_ADDR    = 7'b0010000,
  parameter logic [BYTE_W-1:0] DFLT_SEED   = 8'hA0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_cs_n,
  input  logic                       spi_sclk,
  input  logic                       spi_sdi,
  input  logic                       defaults_req,
  output logic                       spi_mode,
  output logic [NUM_REGS*BYTE_W-1:0] reg_image
);
  logic cs_high, sclk_rise, sdi_bit;
  logic wr_valid, wr_ready;
  logic [PTR_W-1:0]  wr_addr;
  logic [BYTE_W-1:0] wr_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_pin(spi_cs_n), .sclk_pin(spi_sclk), .sdi_pin(spi_sdi),
    .cs_high(cs_high), .sclk_rise(sclk_rise), .sdi_bit(sdi_bit),
    .mode_latched(spi_mode)
  );

  spi_frame_decoder #(.DEV_ADDR(DEV_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .enable(spi_mode),
    .cs_high(cs_high), .sclk_rise(sclk_rise), .sdi_bit(sdi_bit),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS), .DFLT_SEED(DFLT_SEED)) u_bank (
    .clk(clk), .rst_n(rst_n), .defaults_req(defaults_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_image(reg_image)
  );

  // R3
  no_write_while_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_high && !wr_valid) |=> !wr_valid);
endmodule

// File: tb/tb_spi_regwrite_port.sv
module tb_spi_regwrite_port;
  localparam int NR   = 8;
  localparam int HALF = 3;
  localparam logic [7:0] SEED = 8'hA0;
  localparam logic [6:0] DEV  = 7'b0010000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sclk = 1'b0, sdi = 1'b0, dreq = 1'b0;
  logic spi_mode;
  logic [NR*8-1:0] reg_image;
  logic [7:0] expv [NR];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_regwrite_port #(.NUM_REGS(NR), .DEV_ADDR(DEV), .DFLT_SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
    .defaults_req(dreq), .spi_mode(spi_mode), .reg_image(reg_image)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    logic [NR*8-1:0] e;
    for (int i = 0; i < NR; i++) e[i*8 +: 8] = expv[i];
    n_chk++;
    if (reg_image !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, reg_image, e);
    end
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NR; i++) expv[i] = SEED ^ 8'(i);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int k = 7; k > 7 - nbits; k--) begin
      sdi = b[k];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  // Model write for a matched frame.
  task automatic model_write(input int addr, input logic [7:0] d);
    if (addr < NR) expv[addr] = d;
  endtask

  initial begin
    // Watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    load_defaults();
    // Select held low through reset (tied-low case).
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    check_regs("R1 defaults after reset");
    check_bit("R1 mode flag after reset", spi_mode, 1'b0);
    // R3: clock edges with mode off / select tied low do nothing
    send_bits({DEV, 1'b0}, 8);
    send_bits(8'h01, 8);
    send_bits(8'h77, 8);
    wait_clk(6);
    check_bit("R2 tied-low select keeps mode 0", spi_mode, 1'b0);
    check_regs("R2 no writes before mode latched");
    cs_n = 1'b1;
    wait_clk(8);
    check_bit("R2 rising select alone keeps mode 0", spi_mode, 1'b0);
    sel();
    wait_clk(4);
    check_bit("R2 mode set after select falls", spi_mode, 1'b1);
    desel();
    check_bit("R2 mode stays set", spi_mode, 1'b1);

    // R3: bit clocks while deselected are ignored
    send_bits(8'hFF, 8);
    send_bits(8'h00, 5);
    // R6/R9: single writes to every address and a few beyond
    for (int a = 0; a < NR + 3; a++) begin
      logic [7:0] d;
      d = 8'(a * 37 + 11);
      sel();
      send_bits({DEV, 1'b0}, 8);
      send_bits({1'b0, 7'(a)}, 8);
      send_bits(d, 8);
      desel();
      model_write(a, d);
      check_regs(a < NR ? "R6 single write" : "R9 out-of-range write dropped");
    end

    // R4/R5: header sweep over all addresses and both directions
    for (int h = 0; h < 256; h++) begin
      logic [7:0] d;
      int p;
      d = 8'(h) ^ 8'h5A;
      p = (h * 3) % NR;
      sel();
      send_bits(8'(h), 8);
      send_bits(8'(p), 8);
      send_bits(d, 8);
      desel();
      if (h[7:1] == DEV && h[0] == 1'b0) model_write(p, d);
      check_regs(h[0] ? "R5 header sweep" : "R4 header sweep");
    end

    // R7: fixed pointer bursts from each start
    for (int s = 0; s < NR; s++) begin
      sel();
      send_bits({DEV, 1'b0}, 8);
      send_bits({1'b0, 7'(s)}, 8);
      for (int k = 0; k < 3; k++) send_bits(8'(s * 16 + k + 1), 8);
      desel();
      model_write(s, 8'(s * 16 + 3));
      check_regs("R7 fixed pointer burst last wins");
    end

    // R8: stepping bursts from each start, crossing the top of the bank
    for (int s = 0; s < NR; s++) begin
      sel();
      send_bits({DEV, 1'b0}, 8);
      send_bits({1'b1, 7'(s)}, 8);
      for (int k = 0; k < 4; k++) begin
        send_bits(8'(8'hC0 + s * 4 + k), 8);
        model_write(s + k, 8'(8'hC0 + s * 4 + k));
      end
      desel();
      check_regs("R8 stepping burst");
    end

    // R8: wrap from 127 to 0
    sel();
    send_bits({DEV, 1'b0}, 8);
    send_bits({1'b1, 7'd127}, 8);
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    send_bits(8'h33, 8);
    desel();
    model_write(0, 8'h22);
    model_write(1, 8'h33);
    check_regs("R8 pointer wrap 127 to 0");

    // R10: partial data byte dropped, next frame starts fresh
    sel();
    send_bits({DEV, 1'b0}, 8);
    send_bits({1'b0, 7'd2}, 8);
    send_bits(8'hE7, 5);
    desel();
    check_regs("R10 partial data byte dropped");
    sel();
    send_bits({DEV, 1'b0}, 3);
    desel();
    sel();
    send_bits({DEV, 1'b0}, 8);
    send_bits({1'b0, 7'd5}, 8);
    send_bits(8'h3C, 8);
    desel();
    model_write(5, 8'h3C);
    check_regs("R10 frame after cut header decodes");

    // R11: defaults request
    dreq = 1'b1;
    wait_clk(1);
    dreq = 1'b0;
    wait_clk(2);
    load_defaults();
    check_regs("R11 defaults restored");
    check_bit("R11 mode flag untouched", spi_mode, 1'b1);

    // R1: reset again with select high
    rst_n = 1'b0;
    cs_n = 1'b1;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(10);
    check_bit("R1 mode flag after second reset", spi_mode, 1'b0);
    check_regs("R1 defaults after second reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule